// File: doc/BRIEF.md
# Reversible-Gate Four-Way Selector

This block picks one of four data bits under a two-bit select, using only a fixed netlist of reversible gate cells. Every cell has the same number of outputs as inputs. Constant ancilla bits feed the cells where a complement or a clean product target is needed. Every cell output that does not reach the result is exposed on a garbage bus, so that no information is lost inside the block.

The netlist has nine cells. Two two-input XOR cells complement the select bits. Four three-control AND cells form the product terms. Three more XOR cells merge those terms into the result.

The select literals are not fanned out. They are chained from one AND cell to the next, so every cell output is either consumed exactly once or appears on the garbage bus. This yields eleven garbage bits. The block is purely combinational and is meant to be instantiated wherever a reversible-logic datapath needs a selector with observable garbage.

Top module: `rev_mux4`

## Requirements
- R1: `y_o` equals I0·S0'·S1' + I1·S0'·S1 + I2·S0·S1' + I3·S0·S1. Here S0 = `sel_i[1]` is the more significant select bit, S1 = `sel_i[0]`, and Ik = `data_i[k]`.
- R2: The complemented select literals leave on the garbage bus: `garb_o[4]` = S0' and `garb_o[5]` = S1'.
- R3: The product terms are formed by three-control AND cells with a zero ancilla. `garb_o[8]` = I0·S0'·S1' and `garb_o[9]` = I2·S0·S1'.
- R4: The product terms are merged by XOR, which is valid because at most one term can be 1. `garb_o[10]` = (I0·S0'·S1') XOR (I1·S0'·S1).
- R5: The data control lines pass through unchanged: `garb_o[3:0]` = `data_i[3:0]`.
- R6: The true select literals leave the last AND cell unchanged: `garb_o[6]` = S0 and `garb_o[7]` = S1.
- R7: The garbage bus is exactly 11 bits wide, which matches the nine-cell netlist.
- R8: A data bit that is not selected has no effect on `y_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 4 | Data bits I0..I3 (bit k is Ik) |
| sel_i | input | 2 | Select; bit 1 is S0 (MSB), bit 0 is S1 |
| y_o | output | 1 | Selected data bit |
| garb_o | output | 11 | Unused cell outputs, positions as in R2 to R6 |

## Verification
The sweep covers all 64 data and select combinations. It compares the output with a reference selector computed arithmetically. Each garbage field is checked against its own product or literal equation.

A wrongly ordered select, such as treating S1 as the MSB, swaps the I1 and I2 results. A missing complement ancilla leaves a literal uncomplemented, so both the term and garbage bits 4 and 5 go wrong. An OR-style merge or a miswired chain shows up as a wrong `garb_o[10]` or a wrong output when an unselected data bit is toggled. A garbage bus that is shuffled or the wrong width fails the per-field checks.

// File: rtl/rev_pkg.sv
package rev_pkg;
  localparam int unsigned N_DATA   = 4;
  localparam int unsigned N_SEL    = 2;
  localparam int unsigned N_FG     = 5;
  localparam int unsigned N_AND    = 4;
  localparam int unsigned N_GATES  = N_FG + N_AND;
  localparam int unsigned N_GARB   = 11;
  // ancilla constants
  localparam logic FG_NOT_ANC = 1'b1;
  localparam logic AND_ANC    = 1'b0;
  localparam logic FG_CPY_ANC = 1'b0;
  // garbage bus positions
  localparam int unsigned G_DATA  = 0;
  localparam int unsigned G_S0N   = 4;
  localparam int unsigned G_S1N   = 5;
  localparam int unsigned G_S0    = 6;
  localparam int unsigned G_S1    = 7;
  localparam int unsigned G_P0    = 8;
  localparam int unsigned G_P2    = 9;
  localparam int unsigned G_Q01   = 10;
endpackage

// File: rtl/rev_feynman.sv
// (a, b) -> (a, a ^ b)
module rev_feynman (
  input  logic a_i,
  input  logic b_i,
  output logic a_o,
  output logic x_o
);
  assign a_o = a_i;
  assign x_o = a_i ^ b_i;
endmodule

// File: rtl/rev_and3.sv
// (a, b, c, t) -> (a, b, c, a&b&c ^ t)
module rev_and3 (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  input  logic t_i,
  output logic a_o,
  output logic b_o,
  output logic c_o,
  output logic t_o
);
  assign a_o = a_i;
  assign b_o = b_i;
  assign c_o = c_i;
  assign t_o = (a_i & b_i & c_i) ^ t_i;
endmodule

// File: rtl/rev_mux4.sv
module rev_mux4
  import rev_pkg::*;
(
  input  logic [N_DATA-1:0] data_i,
  input  logic [N_SEL-1:0]  sel_i,
  output logic              y_o,
  output logic [N_GARB-1:0] garb_o
);
  logic s0, s1;
  logic s0_c, s0_n, s1_c, s1_n;
  logic [N_DATA-1:0] d_pass;
  logic [N_AND-1:0]  term;
  logic a_s0n, a_s1n;
  logic b_s0n, b_s1;
  logic c_s0, c_s1n;
  logic d_s0, d_s1;
  logic q01_g, q01, p2_g, q23;

  assign s0 = sel_i[1];
  assign s1 = sel_i[0];

  rev_feynman u_not_s0 (.a_i(s0), .b_i(FG_NOT_ANC), .a_o(s0_c), .x_o(s0_n));
  rev_feynman u_not_s1 (.a_i(s1), .b_i(FG_NOT_ANC), .a_o(s1_c), .x_o(s1_n));

  // select literals are chained, never fanned out
  rev_and3 u_t0 (.a_i(data_i[0]), .b_i(s0_n),  .c_i(s1_n),  .t_i(AND_ANC),
                 .a_o(d_pass[0]), .b_o(a_s0n), .c_o(a_s1n), .t_o(term[0]));
  rev_and3 u_t1 (.a_i(data_i[1]), .b_i(a_s0n), .c_i(s1_c),  .t_i(AND_ANC),
                 .a_o(d_pass[1]), .b_o(b_s0n), .c_o(b_s1),  .t_o(term[1]));
  rev_and3 u_t2 (.a_i(data_i[2]), .b_i(s0_c),  .c_i(a_s1n), .t_i(AND_ANC),
                 .a_o(d_pass[2]), .b_o(c_s0),  .c_o(c_s1n), .t_o(term[2]));
  rev_and3 u_t3 (.a_i(data_i[3]), .b_i(c_s0),  .c_i(b_s1),  .t_i(AND_ANC),
                 .a_o(d_pass[3]), .b_o(d_s0),  .c_o(d_s1),  .t_o(term[3]));

  rev_feynman u_x01 (.a_i(term[0]), .b_i(term[1]), .a_o(q01_g), .x_o(q01));
  rev_feynman u_x23 (.a_i(term[2]), .b_i(term[3]), .a_o(p2_g),  .x_o(q23));
  rev_feynman u_xo  (.a_i(q01),     .b_i(q23),     .a_o(garb_o[G_Q01]), .x_o(y_o));

  assign garb_o[G_DATA +: N_DATA] = d_pass;
  assign garb_o[G_S0N] = b_s0n;
  assign garb_o[G_S1N] = c_s1n;
  assign garb_o[G_S0]  = d_s0;
  assign garb_o[G_S1]  = d_s1;
  assign garb_o[G_P0]  = q01_g;
  assign garb_o[G_P2]  = p2_g;

  always_comb begin
    if (!$isunknown({data_i, sel_i})) begin
      p_select_r1: assert (y_o == data_i[sel_i])
        else $error("R1 selected bit mismatch");
      p_terms_onehot_r4: assert ($onehot0(term))
        else $error("R4 more than one product term high");
      p_literals_r2: assert (garb_o[G_S0N] == ~sel_i[1] && garb_o[G_S1N] == ~sel_i[0])
        else $error("R2 complement literal wrong");
      p_sel_pass_r6: assert (garb_o[G_S0] == sel_i[1] && garb_o[G_S1] == sel_i[0])
        else $error("R6 select pass-through wrong");
      p_data_pass_r5: assert (garb_o[G_DATA +: N_DATA] == data_i)
        else $error("R5 data pass-through wrong");
      p_term_r3: assert (term[sel_i] == data_i[sel_i])
        else $error("R3 product term wrong");
    end
  end
endmodule

// File: tb/sim_rev_mux4.sv
module sim_rev_mux4;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0]  data;
  logic [1:0]  sel;
  logic        y;
  logic [10:0] garb;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rev_mux4 u0 (.data_i(data), .sel_i(sel), .y_o(y), .garb_o(garb));

  task automatic chk(input string req, input logic [10:0] got, input logic [10:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s data=%b sel=%b actual=%0h expected=%0h", req, data, sel, got, exp);
    end
  endtask

  initial begin
    data = '0; sel = '0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    chk("R7", 11'($bits(u0.garb_o)), 11'd11);
    for (int v = 0; v < 64; v++) begin
      @(posedge clk);
      data = v[3:0];
      sel  = v[5:4];
      @(negedge clk);
      begin
        logic s0, s1, p0, p1, p2, ref_y;
        s0 = sel[1]; s1 = sel[0];
        p0 = data[0] & ~s0 & ~s1;
        p1 = data[1] & ~s0 &  s1;
        p2 = data[2] &  s0 & ~s1;
        ref_y = p0 | p1 | p2 | (data[3] & s0 & s1);
        chk("R1", {10'd0, y}, {10'd0, ref_y});
        chk("R2", {9'd0, garb[5:4]}, {9'd0, ~s1, ~s0});
        chk("R3", {9'd0, garb[9:8]}, {9'd0, p2, p0});
        chk("R4", {10'd0, garb[10]}, {10'd0, p0 ^ p1});
        chk("R5", {7'd0, garb[3:0]}, {7'd0, data});
        chk("R6", {9'd0, garb[7:6]}, {9'd0, s1, s0});
      end
      // R8: flip every unselected data bit, output must hold
      begin
        logic keep;
        keep = y;
        data = data ^ ~(4'b1 << sel);
        #1;
        chk("R8", {10'd0, y}, {10'd0, keep});
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule